// File: doc/BRIEF.md
# Pipelined Bus Cycle Monitor

This block sits beside a processor's local bus and only listens. It samples the three cycle-definition bits, the address strobe, the transfer-ready, the lock line, the word address, the two byte enables and the data bus on every rising clock edge. From these it works out the clock in which each bus cycle truly begins, including the pipelined case where the next strobe is already waiting while the current cycle still runs. It then reports the decoded cycle type, a registered lock level, and a completion pulse that carries the type of the cycle that just ended.

Read-type cycles also produce a captured data beat. That output is a valid-only stream: a passive monitor cannot stall the bus, so it has no ready input and no back-pressure. Any consumer must take every beat in the clock its valid is high. Protocol errors and overflow of the single pending slot are reported as one-clock pulses. Strobe, ready and lock are active low. The definition code is `{space, kind, dir}`, where space=1 means memory, kind=1 means data and dir=1 means write. All outputs change one clock after the sample that causes them.

Top module: `bus_cycle_monitor`

## Requirements
- R1: At each cycle begin, the definition code maps to `cycle_type` as follows: 000 gives 1 (interrupt acknowledge), 010 gives 2 (I/O read), 011 gives 3 (I/O write), 100 gives 4 (code read), 110 gives 8 (memory read) and 111 gives 9 (memory write). The code 001 gives 15. `cycle_type` reads 0 while no cycle is active.
- R2: With code 101 and `be_n` = 2'b10 (high enable inactive, low enable active), word address `HALT_ADDR` gives type 5 (halt) and word address `SHUT_ADDR` gives type 6 (shutdown). Every other address or enable combination under code 101 gives type 7.
- R3: When no cycle is active, a newly sampled low strobe begins a cycle, and `cycle_start` pulses in the following clock. A strobe still low in the sample right after a begin counts as a new strobe.
- R4: When a new strobe is sampled while a cycle is active and ready is high, it becomes pending. It begins in the sample where ready returns, using the address and definition captured when it became pending. If ready and the new strobe arrive together, the cycle begins at once.
- R5: A sample with ready low while a cycle is active ends that cycle. `cycle_done` pulses in the next clock, and `done_type` carries the ended cycle's type.
- R6: When a cycle of type 1, 2, 4 or 8 ends, `rd_valid` pulses together with `cycle_done`, and `rd_data` holds the data sampled with ready. Write and special cycles never raise `rd_valid`.
- R7: `bus_locked` takes the value of the lock line sampled at each cycle begin. It clears after the ready that ends a cycle when no new cycle begins in that same sample.
- R8: `proto_err` pulses when a beginning cycle of type 2, 3, 4 or 5–7 has lock asserted, or when an interrupt acknowledge begins without lock.
- R9: `proto_err` pulses when code 001 is seen at a cycle begin.
- R10: `proto_err` pulses when a strobe held low across two samples without beginning shows a different address, enable or definition value.
- R11: `ovf_err` pulses when a new strobe is sampled while one is already pending.
- R12: While `rst` is high, all pulses clear, `cycle_type` is 0, `bus_locked` is 0, and no cycle is active or pending. A later ready then ends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address strobe, active low |
| ack_n | input | 1 | Transfer ready, active low |
| lock_n | input | 1 | Bus lock, active low |
| cyc_def | input | 3 | Definition code {space, kind, dir} |
| waddr | input | ADDR_W | Word address |
| be_n | input | 2 | Byte enables {high, low}, active low |
| rd_bus | input | DATA_W | Data bus sampled on read completion |
| cycle_start | output | 1 | One-clock pulse on cycle begin |
| cycle_done | output | 1 | One-clock pulse on cycle end |
| cycle_type | output | 4 | Type of the active cycle, 0 when idle |
| done_type | output | 4 | Type of the cycle reported by cycle_done |
| bus_locked | output | 1 | Registered lock level |
| rd_valid | output | 1 | Captured read beat valid (no back-pressure) |
| rd_data | output | DATA_W | Captured read data |
| proto_err | output | 1 | Protocol error pulse |
| ovf_err | output | 1 | Pending-slot overflow pulse |

## Verification
The bench builds the monitor with `ADDR_W`=4 and `DATA_W`=8. This makes all 16 word addresses, all four byte-enable pairs and both lock levels sweepable under the special code. Every halt, shutdown and other special classification is therefore hit, along with every lock-legality outcome. Pipelined sequences on that configuration cover the pending begin, capture of the pending attributes, lock carried across back-to-back cycles, overflow, and reset in the middle of a cycle.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [3:0] {
    CT_NONE     = 4'd0,
    CT_IACK     = 4'd1,
    CT_IO_RD    = 4'd2,
    CT_IO_WR    = 4'd3,
    CT_CODE_RD  = 4'd4,
    CT_HALT     = 4'd5,
    CT_SHUTDOWN = 4'd6,
    CT_SPECIAL  = 4'd7,
    CT_MEM_RD   = 4'd8,
    CT_MEM_WR   = 4'd9,
    CT_ILLEGAL  = 4'd15
  } cyc_type_e;

  typedef enum logic [1:0] {
    LK_FORBID  = 2'd0,
    LK_REQUIRE = 2'd1,
    LK_EITHER  = 2'd2
  } lock_rule_e;

  localparam int DEF_W = 3;
  localparam int BE_W  = 2;

endpackage

// File: rtl/bcm_decode.sv
module bcm_decode
  import bcm_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int HALT_ADDR = 2,
  parameter int SHUT_ADDR = 0
) (
  input  logic [DEF_W-1:0]  def,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BE_W-1:0]   be_n,
  output cyc_type_e         ctype,
  output lock_rule_e        rule,
  output logic              illegal,
  output logic              is_read
);
  localparam logic [ADDR_W-1:0] HALT_W  = ADDR_W'(HALT_ADDR);
  localparam logic [ADDR_W-1:0] SHUT_W  = ADDR_W'(SHUT_ADDR);
  localparam logic [BE_W-1:0]   SPEC_BE = 2'b10;

  cyc_type_e special_type;

  always_comb begin
    if (be_n == SPEC_BE && waddr == HALT_W)      special_type = CT_HALT;
    else if (be_n == SPEC_BE && waddr == SHUT_W) special_type = CT_SHUTDOWN;
    else                                         special_type = CT_SPECIAL;
  end

  always_comb begin
    illegal = 1'b0;
    is_read = 1'b0;
    rule    = LK_FORBID;
    ctype   = CT_NONE;
    case (def)
      3'b000: begin ctype = CT_IACK;    rule = LK_REQUIRE; is_read = 1'b1; end
      3'b001: begin ctype = CT_ILLEGAL; rule = LK_EITHER;  illegal = 1'b1; end
      3'b010: begin ctype = CT_IO_RD;   is_read = 1'b1; end
      3'b011: begin ctype = CT_IO_WR;   end
      3'b100: begin ctype = CT_CODE_RD; is_read = 1'b1; end
      3'b101: begin ctype = special_type; end
      3'b110: begin ctype = CT_MEM_RD;  rule = LK_EITHER; is_read = 1'b1; end
      default: begin ctype = CT_MEM_WR; rule = LK_EITHER; end
    endcase
  end
endmodule

// File: rtl/bcm_sequencer.sv
module bcm_sequencer
  import bcm_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strb,
  input  logic              rdy,
  input  logic [DEF_W-1:0]  def,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BE_W-1:0]   be_n,
  output logic              begin_now,
  output logic              done_now,
  output logic [DEF_W-1:0]  sel_def,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [BE_W-1:0]   sel_be,
  output logic              overflow,
  output logic              unstable
);
  localparam int ATTR_W = DEF_W + ADDR_W + BE_W;

  logic              busy_q, pend_q, strb_q, began_q;
  logic [ATTR_W-1:0] prev_q, pend_attr_q;
  logic [ATTR_W-1:0] live;
  logic              strb_new, strb_held, pend_set;

  assign live      = {def, waddr, be_n};
  assign strb_new  = strb && (!strb_q || began_q);
  assign strb_held = strb && strb_q && !began_q;
  assign unstable  = strb_held && (live != prev_q);
  assign overflow  = strb_new && pend_q;
  assign done_now  = busy_q && rdy;
  assign pend_set  = !pend_q && strb_new && busy_q && !rdy;

  always_comb begin
    if (pend_q) begin
      begin_now = rdy;
      {sel_def, sel_addr, sel_be} = pend_attr_q;
    end else begin
      begin_now = strb_new && (!busy_q || rdy);
      {sel_def, sel_addr, sel_be} = live;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      pend_q      <= 1'b0;
      strb_q      <= 1'b0;
      began_q     <= 1'b0;
      prev_q      <= '0;
      pend_attr_q <= '0;
    end else begin
      if (begin_now)     busy_q <= 1'b1;
      else if (done_now) busy_q <= 1'b0;
      if (pend_q && rdy) pend_q <= 1'b0;
      else if (pend_set) pend_q <= 1'b1;
      if (pend_set) pend_attr_q <= live;
      strb_q  <= strb;
      began_q <= begin_now;
      prev_q  <= live;
    end
  end
endmodule

// File: rtl/bcm_lock_tracker.sv
module bcm_lock_tracker
  import bcm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       begin_now,
  input  logic       done_now,
  input  logic       lock_live,
  input  lock_rule_e rule,
  output logic       locked_q,
  output logic       violation
);
  always_comb begin
    violation = 1'b0;
    if (begin_now) begin
      if (rule == LK_REQUIRE && !lock_live) violation = 1'b1;
      if (rule == LK_FORBID && lock_live)   violation = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            locked_q <= 1'b0;
    else if (begin_now) locked_q <= lock_live;
    else if (done_now)  locked_q <= 1'b0;
  end
endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor
  import bcm_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int HALT_ADDR = 2,
  parameter int SHUT_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic              ack_n,
  input  logic              lock_n,
  input  logic [2:0]        cyc_def,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [1:0]        be_n,
  input  logic [DATA_W-1:0] rd_bus,
  output logic              cycle_start,
  output logic              cycle_done,
  output logic [3:0]        cycle_type,
  output logic [3:0]        done_type,
  output logic              bus_locked,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              proto_err,
  output logic              ovf_err
);
  logic              begin_now, done_now, overflow, unstable;
  logic [DEF_W-1:0]  sel_def;
  logic [ADDR_W-1:0] sel_addr;
  logic [BE_W-1:0]   sel_be;
  cyc_type_e         dec_type;
  lock_rule_e        dec_rule;
  logic              dec_illegal, dec_read, lock_bad;
  logic              act_read_q;

  bcm_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst),
    .strb(!strobe_n), .rdy(!ack_n),
    .def(cyc_def), .waddr(waddr), .be_n(be_n),
    .begin_now(begin_now), .done_now(done_now),
    .sel_def(sel_def), .sel_addr(sel_addr), .sel_be(sel_be),
    .overflow(overflow), .unstable(unstable)
  );

  bcm_decode #(.ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR), .SHUT_ADDR(SHUT_ADDR)) u_dec (
    .def(sel_def), .waddr(sel_addr), .be_n(sel_be),
    .ctype(dec_type), .rule(dec_rule), .illegal(dec_illegal), .is_read(dec_read)
  );

  bcm_lock_tracker u_lock (
    .clk(clk), .rst(rst),
    .begin_now(begin_now), .done_now(done_now),
    .lock_live(!lock_n), .rule(dec_rule),
    .locked_q(bus_locked), .violation(lock_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cycle_start <= 1'b0;
      cycle_done  <= 1'b0;
      cycle_type  <= CT_NONE;
      done_type   <= CT_NONE;
      act_read_q  <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      proto_err   <= 1'b0;
      ovf_err     <= 1'b0;
    end else begin
      cycle_start <= begin_now;
      cycle_done  <= done_now;
      rd_valid    <= done_now && act_read_q;
      proto_err   <= (begin_now && dec_illegal) || lock_bad || unstable;
      ovf_err     <= overflow;
      if (done_now) done_type <= cycle_type;
      if (done_now && act_read_q) rd_data <= rd_bus;
      if (begin_now) begin
        cycle_type <= dec_type;
        act_read_q <= dec_read;
      end else if (done_now) begin
        cycle_type <= CT_NONE;
        act_read_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker (
  input logic       clk,
  input logic       rst,
  input logic       strobe_n,
  input logic       ack_n,
  input logic       cycle_start,
  input logic       cycle_done,
  input logic [3:0] cycle_type,
  input logic [3:0] done_type,
  input logic       bus_locked,
  input logic       rd_valid,
  input logic       proto_err,
  input logic       ovf_err
);
  logic armed_q;
  always_ff @(posedge clk) armed_q <= !rst;

  p_start_cause_r3: assert property (@(posedge clk) disable iff (rst || !armed_q)
    cycle_start |-> ($past(!strobe_n) || $past(!ack_n)));

  p_done_needs_ready_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
    cycle_done |-> $past(!ack_n));

  p_done_type_r5: assert property (@(posedge clk) disable iff (rst || !armed_q)
    cycle_done |-> (done_type == $past(cycle_type)));

  p_rd_with_done_r6: assert property (@(posedge clk) disable iff (rst || !armed_q)
    rd_valid |-> cycle_done);

  p_lock_rise_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $rose(bus_locked) |-> cycle_start);

  p_lock_fall_r7: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $fell(bus_locked) |-> cycle_done);

  p_iack_locked_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
    (cycle_start && cycle_type == 4'd1 && !proto_err) |-> bus_locked);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst || !armed_q)
    ovf_err |-> $past(!strobe_n));
endmodule

bind bus_cycle_monitor bcm_checker u_chk (
  .clk(clk), .rst(rst), .strobe_n(strobe_n), .ack_n(ack_n),
  .cycle_start(cycle_start), .cycle_done(cycle_done),
  .cycle_type(cycle_type), .done_type(done_type),
  .bus_locked(bus_locked), .rd_valid(rd_valid),
  .proto_err(proto_err), .ovf_err(ovf_err)
);

// File: tb/tb_bus_cycle_monitor.sv
module tb_bus_cycle_monitor;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strobe_n = 1'b1, ack_n = 1'b1, lock_n = 1'b1;
  logic [2:0]    cyc_def = '0;
  logic [AW-1:0] waddr = '0;
  logic [1:0]    be_n = '0;
  logic [DW-1:0] rd_bus = '0;
  logic          cycle_start, cycle_done, bus_locked, rd_valid, proto_err, ovf_err;
  logic [3:0]    cycle_type, done_type;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_cycle_monitor #(.ADDR_W(AW), .DATA_W(DW), .HALT_ADDR(2), .SHUT_ADDR(0)) dut (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .ack_n(ack_n), .lock_n(lock_n),
    .cyc_def(cyc_def), .waddr(waddr), .be_n(be_n), .rd_bus(rd_bus),
    .cycle_start(cycle_start), .cycle_done(cycle_done), .cycle_type(cycle_type),
    .done_type(done_type), .bus_locked(bus_locked), .rd_valid(rd_valid),
    .rd_data(rd_data), .proto_err(proto_err), .ovf_err(ovf_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int s, input int r, input int d, input int a,
                       input int b, input int lk, input int dat);
    @(negedge clk);
    strobe_n = (s == 0);
    ack_n    = (r == 0);
    lock_n   = (lk == 0);
    cyc_def  = 3'(d);
    waddr    = AW'(a);
    be_n     = 2'(b);
    rd_bus   = DW'(dat);
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_type(input int d, input int a, input int b);
    case (d)
      0: return 1;
      1: return 15;
      2: return 2;
      3: return 3;
      4: return 4;
      5: return (b == 2 && a == 2) ? 5 : ((b == 2 && a == 0) ? 6 : 7);
      6: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int exp_read(input int d);
    return (d == 0 || d == 2 || d == 4 || d == 6) ? 1 : 0;
  endfunction

  function automatic int exp_err(input int d, input int lk);
    if (d == 1) return 1;
    if (d >= 2 && d <= 5 && lk != 0) return 1;
    if (d == 0 && lk == 0) return 1;
    return 0;
  endfunction

  task automatic run_cycle(input int d, input int a, input int b, input int lk, input int dat);
    int t;
    t = exp_type(d, a, b);
    drive(1, 0, d, a, b, lk, 0);
    chk("R3 start pulse", int'(cycle_start), 1);
    chk((d == 5) ? "R2 special type" : "R1 decode type", int'(cycle_type), t);
    chk("R7 lock at begin", int'(bus_locked), lk);
    chk((d == 1) ? "R9 illegal code" : "R8 lock rule", int'(proto_err), exp_err(d, lk));
    drive(0, 1, d, a, b, lk, dat);
    chk("R5 done pulse", int'(cycle_done), 1);
    chk("R5 done type", int'(done_type), t);
    chk("R6 rd_valid", int'(rd_valid), exp_read(d));
    if (exp_read(d) != 0) chk("R6 rd_data", int'(rd_data), dat & 8'hFF);
    chk("R7 lock release", int'(bus_locked), 0);
    chk("R1 idle type", int'(cycle_type), 0);
    drive(0, 0, d, a, b, 0, 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset start", int'(cycle_start), 0);
    chk("R12 reset type", int'(cycle_type), 0);
    chk("R12 reset lock", int'(bus_locked), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R6 R7 R8 R9 sweep
    for (int d = 0; d < 8; d++) begin
      for (int lk = 0; lk < 2; lk++) begin
        if (d == 5) begin
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 4; b++)
              run_cycle(d, a, b, lk, a * 16 + b);
        end else begin
          run_cycle(d, d + 3, 0, lk, 8'h30 + d * 4 + lk);
        end
      end
    end

    // R4 pipelined begin with lock carried (R7)
    drive(1, 0, 7, 3, 0, 1, 0);
    chk("R3 idle begin", int'(cycle_start), 1);
    drive(1, 0, 6, 5, 0, 1, 0);
    chk("R4 pending no start", int'(cycle_start), 0);
    chk("R11 no overflow", int'(ovf_err), 0);
    drive(1, 0, 6, 5, 0, 1, 0);
    chk("R10 stable hold", int'(proto_err), 0);
    drive(1, 1, 6, 5, 0, 1, 8'h5A);
    chk("R4 pipelined start", int'(cycle_start), 1);
    chk("R5 done with start", int'(cycle_done), 1);
    chk("R5 done type write", int'(done_type), 9);
    chk("R4 new type", int'(cycle_type), 8);
    chk("R6 write no valid", int'(rd_valid), 0);
    chk("R7 lock carried", int'(bus_locked), 1);
    drive(0, 1, 0, 0, 0, 0, 8'hC3);
    chk("R6 read valid", int'(rd_valid), 1);
    chk("R6 read data", int'(rd_data), 8'hC3);
    chk("R7 lock released", int'(bus_locked), 0);
    drive(0, 0, 0, 0, 0, 0, 0);

    // R10 change while held; R4 captured attributes
    drive(1, 0, 4, 1, 0, 0, 0);
    drive(1, 0, 2, 6, 0, 0, 0);
    chk("R10 no err first", int'(proto_err), 0);
    drive(1, 0, 3, 7, 0, 0, 0);
    chk("R10 changed while held", int'(proto_err), 1);
    drive(1, 1, 3, 7, 0, 0, 8'h11);
    chk("R4 captured type", int'(cycle_type), 2);
    chk("R5 done code read", int'(done_type), 4);
    chk("R6 code read data", int'(rd_data), 8'h11);
    drive(0, 1, 0, 0, 0, 0, 8'h22);
    chk("R5 io read done", int'(done_type), 2);
    drive(0, 0, 0, 0, 0, 0, 0);

    // R11 overflow
    drive(1, 0, 7, 1, 0, 0, 0);
    drive(1, 0, 6, 2, 0, 0, 0);
    drive(0, 0, 6, 2, 0, 0, 0);
    chk("R11 pending quiet", int'(ovf_err), 0);
    drive(1, 0, 6, 2, 0, 0, 0);
    chk("R11 overflow", int'(ovf_err), 1);
    drive(0, 1, 0, 0, 0, 0, 0);
    chk("R4 pending begins", int'(cycle_start), 1);
    chk("R4 pending type", int'(cycle_type), 8);
    drive(0, 1, 0, 0, 0, 0, 8'h77);
    chk("R6 after overflow", int'(rd_data), 8'h77);
    drive(0, 0, 0, 0, 0, 0, 0);

    // R12 reset mid-cycle
    drive(1, 0, 7, 4, 0, 1, 0);
    chk("R7 locked before reset", int'(bus_locked), 1);
    @(negedge clk);
    rst = 1'b1;
    strobe_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R12 lock cleared", int'(bus_locked), 0);
    chk("R12 type cleared", int'(cycle_type), 0);
    @(negedge clk);
    rst = 1'b0;
    drive(0, 1, 0, 0, 0, 0, 0);
    chk("R12 ready ends nothing", int'(cycle_done), 0);
    drive(0, 0, 0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule